// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block sits in a receive path and decides, from the destination address at the head of each incoming frame, whether the frame is kept. Bytes arrive one per cycle when `in_valid` is high. `in_sof` marks the first byte. After the sixth address byte, the block raises a one-cycle decision strobe. The strobe carries an accept flag and a reason code.

The rules are checked in a fixed order. A disabled receiver drops everything. Promiscuous mode keeps everything. Otherwise the address is compared against the station address, then against the all-ones broadcast address, and finally, when hashing is on, against a 64-bit multicast hash table. The hash index is taken from a reflected CRC-32 that is built up byte by byte while the address streams in. No copy of the address is buffered.

Top module: `rx_addr_filter`

## Requirements
- R1: When `cfg_rx_en` is 0 at the sixth address byte, the decision is reject with reason code 0 (disabled), whatever the other settings and the address.
- R2: When receive is enabled and `cfg_promisc` is 1, the decision is accept with reason code 1 (promiscuous), whatever the address, including one that matches the station address.
- R3: Otherwise, if the six destination bytes equal the station address, the decision is accept with reason code 2 (station). Byte 0 is in `sta_addr[15:8]`, byte 1 in `[7:0]`, bytes 2 and 3 in `[31:24]` and `[23:16]`, and bytes 4 and 5 in `[47:40]` and `[39:32]`. A station match takes priority over a broadcast match.
- R4: Otherwise, a destination of six 0xFF bytes is accepted with reason code 3 (broadcast).
- R5: Otherwise, if `cfg_hash_en` is 1, the block uses an index equal to bits 31:26 of a CRC-32. The CRC is preset to 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, processes each byte LSB first over the six bytes in order, and is not inverted. Index bits 5:4 select 16-bit word k of `hash_tbl` (bits 16k+15:16k), and index bits 3:0 select the bit in that word, so the bit tested is `hash_tbl[index]`. A 1 accepts with reason code 4 (hash hit). A 0 rejects with reason code 5 (hash miss).
- R6: Otherwise (no match and hashing disabled), the decision is reject with reason code 6 (no match).
- R7: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the sixth address byte. Idle cycles between address bytes are allowed and do not change the result.
- R8: A byte with `in_valid` and `in_sof` both high always restarts evaluation as byte 0, abandoning any partial address. The abandoned frame produces no decision.
- R9: Valid bytes that arrive without a start-of-frame while no frame is open are ignored. This covers bytes beyond the sixth of a frame and bytes after reset with no start. They produce no decision.
- R10: After reset, `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A frame byte is present on `in_byte` |
| in_sof | input | 1 | The present byte is the first byte of a frame |
| in_byte | input | 8 | Frame byte |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_hash_en | input | 1 | Enable multicast hash check |
| sta_addr | input | 48 | Station address, three 16-bit words |
| hash_tbl | input | 64 | Hash table, four 16-bit words |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted (valid with strobe) |
| dec_reason | output | 3 | Reason code (valid with strobe) |

## Verification
The hash path is the hardest to reach from the ports. An address lands on a given table bit only through its CRC, so a hit cannot be aimed without computing that CRC. The bench computes the reflected CRC itself for each address. It then sweeps a one-hot table across all 64 positions, so that exactly one position should accept. It also tests many addresses against tables that include or exclude the computed bit. The start-of-frame abort is reached by cutting a partial address short with a new start byte and counting decision strobes.

// File: rtl/rxf_pkg.sv
// Shared types for the receive address filter.
// Reason codes are part of the block's interface; values are fixed.
package rxf_pkg;
    typedef enum logic [2:0] {
        RSN_DISABLED  = 3'd0,
        RSN_PROMISC   = 3'd1,
        RSN_STATION   = 3'd2,
        RSN_BCAST     = 3'd3,
        RSN_HASH_HIT  = 3'd4,
        RSN_HASH_MISS = 3'd5,
        RSN_NO_MATCH  = 3'd6
    } reason_e;

    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;
endpackage

// File: rtl/rxf_crc_step.sv
// Reflected CRC advanced one byte per accepted beat.
// Assumes: start and step come from the frame tracker; start implies step.
// crc_next includes the current byte so the last byte needs no extra cycle.
module rxf_crc_step #(
    parameter int                BYTE_W = 8,
    parameter int                CRC_W  = 32,
    parameter logic [CRC_W-1:0]  POLY   = 32'hEDB88320,
    parameter logic [CRC_W-1:0]  PRESET = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] c;
    logic             fb;

    // Shift the current byte through the CRC, LSB first.
    always_comb begin
        c = start ? PRESET : crc_q;
        fb = 1'b0;
        for (int b = 0; b < BYTE_W; b++) begin
            fb = c[0] ^ din[b];
            c  = c >> 1;
            if (fb) c = c ^ POLY;
        end
        crc_next = c;
    end

    // Hold the running CRC between beats.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= PRESET;
        else if (step) crc_q <= crc_next;
    end
endmodule

// File: rtl/rxf_addr_track.sv
// Streaming comparison of destination bytes against the station address
// and the all-ones broadcast address.
// Assumes: station word w holds byte 2w in its upper byte, 2w+1 in its lower.
module rxf_addr_track #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 6,
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        step,
    input  logic [CNT_W-1:0]            idx,
    input  logic [BYTE_W-1:0]           din,
    input  logic [NUM_BYTES*BYTE_W-1:0] sta_addr,
    output logic                        sta_hit_next,
    output logic                        bc_hit_next
);
    localparam int BPW = WORD_W / BYTE_W;

    logic [BYTE_W-1:0] sta_bytes [NUM_BYTES];
    logic              sta_q, bc_q;
    logic              sta_prev, bc_prev;

    // Unpack station words into destination byte order.
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sta
        assign sta_bytes[i] =
            sta_addr[(i / BPW) * WORD_W + (BPW - 1 - (i % BPW)) * BYTE_W +: BYTE_W];
    end

    // Fold the present byte into the match flags.
    always_comb begin
        sta_prev     = start ? 1'b1 : sta_q;
        bc_prev      = start ? 1'b1 : bc_q;
        sta_hit_next = sta_prev & (din == sta_bytes[idx]);
        bc_hit_next  = bc_prev & (&din);
    end

    // Keep the flags across beats of one address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q <= 1'b0;
            bc_q  <= 1'b0;
        end else if (step) begin
            sta_q <= sta_hit_next;
            bc_q  <= bc_hit_next;
        end
    end
endmodule

// File: rtl/rxf_decide.sv
// Fixed-priority decision: disabled, promiscuous, station, broadcast, hash.
// Assumes: hash_tbl word k occupies bits 16k+15:16k, so the index is a flat bit number.
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int HASH_IDX_W = 6
) (
    input  logic                     rx_en,
    input  logic                     promisc,
    input  logic                     hash_en,
    input  logic                     sta_hit,
    input  logic                     bc_hit,
    input  logic [HASH_IDX_W-1:0]    hash_idx,
    input  logic [2**HASH_IDX_W-1:0] hash_tbl,
    output logic                     accept,
    output reason_e                  reason
);
    // Walk the rules in priority order.
    always_comb begin
        if (!rx_en) begin
            accept = 1'b0; reason = RSN_DISABLED;
        end else if (promisc) begin
            accept = 1'b1; reason = RSN_PROMISC;
        end else if (sta_hit) begin
            accept = 1'b1; reason = RSN_STATION;
        end else if (bc_hit) begin
            accept = 1'b1; reason = RSN_BCAST;
        end else if (hash_en) begin
            accept = hash_tbl[hash_idx];
            reason = hash_tbl[hash_idx] ? RSN_HASH_HIT : RSN_HASH_MISS;
        end else begin
            accept = 1'b0; reason = RSN_NO_MATCH;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter top.
// Tracks byte position in the address, feeds the CRC and comparators,
// and registers one decision after the last address byte.
// Assumes: configuration is stable while an address streams in; it is
// sampled on the last address byte.
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int NUM_BYTES  = 6,
    parameter int WORD_W     = 16,
    parameter int HASH_WORDS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic                                in_sof,
    input  logic [BYTE_W-1:0]                   in_byte,
    input  logic                                cfg_rx_en,
    input  logic                                cfg_promisc,
    input  logic                                cfg_hash_en,
    input  logic [NUM_BYTES*BYTE_W-1:0]         sta_addr,
    input  logic [HASH_WORDS*WORD_W-1:0]        hash_tbl,
    output logic                                dec_valid,
    output logic                                dec_accept,
    output logic [2:0]                          dec_reason
);
    localparam int CNT_W      = $clog2(NUM_BYTES);
    localparam int HASH_IDX_W = $clog2(HASH_WORDS * WORD_W);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cur_idx;
    logic             start, step, last;
    logic [CRC_W-1:0] crc_next;
    logic             sta_hit, bc_hit, acc_c;
    reason_e          rsn_c;
    reason_e          rsn_q;

    // Classify the present beat.
    always_comb begin
        start   = in_valid & in_sof;
        step    = in_valid & (in_sof | active);
        cur_idx = in_sof ? '0 : cnt;
        last    = step & (cur_idx == CNT_W'(NUM_BYTES - 1));
    end

    // Byte position within the address; closes after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (step) begin
            if (last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                active <= 1'b1;
                cnt    <= cur_idx + 1'b1;
            end
        end
    end

    rxf_crc_step #(
        .BYTE_W (BYTE_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .PRESET (CRC_PRESET)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .step     (step),
        .din      (in_byte),
        .crc_next (crc_next)
    );

    rxf_addr_track #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES),
        .WORD_W    (WORD_W),
        .CNT_W     (CNT_W)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .step         (step),
        .idx          (cur_idx),
        .din          (in_byte),
        .sta_addr     (sta_addr),
        .sta_hit_next (sta_hit),
        .bc_hit_next  (bc_hit)
    );

    rxf_decide #(
        .HASH_IDX_W (HASH_IDX_W)
    ) u_decide (
        .rx_en    (cfg_rx_en),
        .promisc  (cfg_promisc),
        .hash_en  (cfg_hash_en),
        .sta_hit  (sta_hit),
        .bc_hit   (bc_hit),
        .hash_idx (crc_next[CRC_W-1 -: HASH_IDX_W]),
        .hash_tbl (hash_tbl),
        .accept   (acc_c),
        .reason   (rsn_c)
    );

    // Register the decision one cycle after the last address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            rsn_q      <= RSN_DISABLED;
        end else begin
            dec_valid <= last;
            if (last) begin
                dec_accept <= acc_c;
                rsn_q      <= rsn_c;
            end
        end
    end

    assign dec_reason = rsn_q;

    // R1: a disabled receiver rejects at the decision.
    assert_disabled_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !cfg_rx_en) |=> (dec_valid && !dec_accept && dec_reason == RSN_DISABLED));

    // R2: promiscuous mode accepts at the decision.
    assert_promisc_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (last && cfg_rx_en && cfg_promisc) |=> (dec_valid && dec_accept && dec_reason == RSN_PROMISC));

    // R7: the strobe lasts one cycle.
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R7: a strobe is always preceded by a valid byte.
    assert_strobe_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid));
endmodule

// File: tb/rx_addr_filter_bench.sv
// Self-checking bench for the receive address filter.
module rx_addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        cfg_rx_en = 1'b0;
    logic        cfg_promisc = 1'b0;
    logic        cfg_hash_en = 1'b0;
    logic [47:0] sta_addr = 48'h0;
    logic [63:0] hash_tbl = 64'h0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_reason;

    int checks = 0;
    int fails = 0;
    int strobes = 0;

    always #2 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sof (in_sof),
        .in_byte (in_byte), .cfg_rx_en (cfg_rx_en), .cfg_promisc (cfg_promisc),
        .cfg_hash_en (cfg_hash_en), .sta_addr (sta_addr), .hash_tbl (hash_tbl),
        .dec_valid (dec_valid), .dec_accept (dec_accept), .dec_reason (dec_reason)
    );

    always @(negedge clk) if (dec_valid) strobes++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc6(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47 - 8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                logic f = c[0] ^ b[k];
                c = c >> 1;
                if (f) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    function automatic logic [47:0] station48();
        return {sta_addr[15:0], sta_addr[31:16], sta_addr[47:32]};
    endfunction

    function automatic int expect_rsn(input logic [47:0] a);
        logic [5:0] ix;
        if (!cfg_rx_en) return 0;
        if (cfg_promisc) return 1;
        if (a == station48()) return 2;
        if (a == 48'hFFFF_FFFF_FFFF) return 3;
        if (cfg_hash_en) begin
            ix = crc6(a) >> 26;
            return hash_tbl[ix] ? 4 : 5;
        end
        return 6;
    endfunction

    function automatic string tag_of(input int r);
        case (r)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic send_bytes(input logic [47:0] a, input int n, input bit sof, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = sof && (i == 0);
            in_byte  = a[47 - 8*i -: 8];
            if (gap && i < n - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
            end
        end
    endtask

    task automatic run_frame(input logic [47:0] a, input bit gap, input string xtag);
        int r = expect_rsn(a);
        int acc = (r >= 1 && r <= 4) ? 1 : 0;
        send_bytes(a, 6, 1'b1, gap);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        check({xtag, tag_of(r), " strobe R7"}, dec_valid, 1);
        check({xtag, tag_of(r), " accept"}, dec_accept, acc);
        check({xtag, tag_of(r), " reason"}, dec_reason, r);
        @(negedge clk);
        check({xtag, "R7 strobe width"}, dec_valid, 0);
    endtask

    initial begin
        #600000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [47:0] addrs [5];
        logic [47:0] a;
        logic [5:0]  ix;
        int s0;

        repeat (3) @(negedge clk);
        check("R10 reset strobe", dec_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", dec_valid, 0);

        sta_addr = {16'h4455, 16'h2233, 16'h0211};
        hash_tbl = 64'hA5C3_0F96_3C5A_F00F;
        addrs[0] = 48'h0211_2233_4455;
        addrs[1] = 48'hFFFF_FFFF_FFFF;
        addrs[2] = 48'h0100_5E00_0001;
        addrs[3] = 48'h3333_0000_00FB;
        addrs[4] = 48'h0211_2233_4454;

        // Configuration sweep across all rule combinations: R1 R2 R3 R4 R5 R6
        for (int c = 0; c < 8; c++) begin
            cfg_rx_en = c[0]; cfg_promisc = c[1]; cfg_hash_en = c[2];
            for (int j = 0; j < 5; j++) run_frame(addrs[j], 1'b0, "sweep ");
        end

        // Exhaustive one-hot hash table: only the CRC index accepts (R5)
        cfg_rx_en = 1'b1; cfg_promisc = 1'b0; cfg_hash_en = 1'b1;
        for (int k = 0; k < 64; k++) begin
            hash_tbl = 64'h1 << k;
            run_frame(48'h0100_5E7F_1234, 1'b0, "onehot ");
        end

        // Many addresses against tables with and without their bit (R5)
        for (int j = 0; j < 24; j++) begin
            a = {8'h01, 8'h00, 8'h5E, j[7:0], 8'hA0 ^ j[7:0], j[7:0] * 8'd7};
            ix = crc6(a) >> 26;
            hash_tbl = 64'h1 << ix;
            run_frame(a, 1'b0, "hit ");
            hash_tbl = ~(64'h1 << ix);
            run_frame(a, 1'b0, "miss ");
        end

        // Station wins over broadcast when both match (R3)
        sta_addr = 48'hFFFF_FFFF_FFFF;
        cfg_hash_en = 1'b0;
        run_frame(48'hFFFF_FFFF_FFFF, 1'b0, "prio ");
        check("R3 station over broadcast", dec_reason, 2);
        sta_addr = {16'h4455, 16'h2233, 16'h0211};

        // Idle gaps between address bytes (R7)
        run_frame(48'h0211_2233_4455, 1'b1, "gap ");
        run_frame(48'h0211_2233_4456, 1'b1, "gap ");

        // Start-of-frame aborts a partial address (R8)
        s0 = strobes;
        send_bytes(48'hFFFF_FFFF_FFFF, 3, 1'b1, 1'b0);
        run_frame(48'h0211_2233_4455, 1'b0, "abort ");
        check("R8 single strobe after abort", strobes - s0, 1);
        s0 = strobes;
        send_bytes(48'h0211_2233_4455, 5, 1'b1, 1'b0);
        run_frame(48'hFFFF_FFFF_FFFF, 1'b0, "abort5 ");
        check("R8 abort at fifth byte", strobes - s0, 1);

        // Bytes without a start while idle are ignored (R9)
        s0 = strobes;
        send_bytes(48'h0211_2233_4455, 6, 1'b0, 1'b0);
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 no strobe without start", strobes - s0, 0);
        // Trailing bytes after a full address are ignored (R9)
        send_bytes(48'h0211_2233_4455, 6, 1'b1, 1'b0);
        send_bytes(48'h0211_2233_4455, 6, 1'b0, 1'b0);
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 trailing bytes single strobe", strobes - s0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule